// File: doc/BRIEF.md
# Single Operand Function Unit

This unit performs the data step of a single-operand instruction once the operand has been fetched from its effective address. An operation select chooses one of ten data operations (clear, fill with ones, complement, two's-complement negate, absolute value, byte exchange, and increment or decrement by one or two). The unit returns the 16-bit value to be written back to the same effective address, one clock after the request.

The unit also handles two branch operations, which use the effective address rather than the operand value. The plain branch loads the program counter with the effective address. The branch-and-link first writes the current program counter into workspace register 11 and then loads the program counter with the effective address. There is no hardware stack. A return is an indirect branch through register 11, and only one level of return address survives unless software saves that register elsewhere.

A combinational `skip_read` output tells the sequencer that the current select does not need the operand, so the read cycle can be omitted. Unassigned select codes are reported as illegal and leave the value unchanged.

Top module: `sop_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every registered output (`res_valid`, `wr_en`, `pc_load`, `link_wr`, `illegal`, `result`, `pc_next`, `link_data`, `link_idx`) becomes zero.
- R2: Select 0 (clear) yields 0x0000 and select 1 (fill) yields 0xFFFF, whatever the operand, with `wr_en` high.
- R3: Select 2 yields the bitwise complement of the operand, with `wr_en` high.
- R4: Select 3 yields 0 minus the operand, modulo 2^16. Negating 0x8000 gives 0x8000, and negating 0 gives 0.
- R5: Select 4 yields the operand when bit 15 is clear and its negation when bit 15 is set. The absolute value of 0x8000 is 0x8000.
- R6: Select 5 exchanges bits 15:8 with bits 7:0.
- R7: Selects 6, 7, 8 and 9 add 1, add 2, subtract 1 and subtract 2, all modulo 2^16 (0xFFFF+1 gives 0x0000, 0xFFFF+2 gives 0x0001, 0x0000-1 gives 0xFFFF, 0x0001-2 gives 0xFFFF).
- R8: Select 10 (branch) raises `pc_load` with `pc_next` equal to the effective address. `wr_en` and `link_wr` stay low.
- R9: Select 11 (branch and link) raises `pc_load` with `pc_next` equal to the effective address. In the same cycle it raises `link_wr` with `link_data` equal to `pc_in` and `link_idx` equal to 11. `wr_en` stays low.
- R10: `skip_read` is high, in the same cycle as the select, exactly for selects 0, 1, 10 and 11.
- R11: Selects 12 to 15 raise `illegal` and return the operand unchanged on `result`. `wr_en`, `pc_load` and `link_wr` stay low.
- R12: Every output registered from a request appears on the clock edge that samples `op_valid` high. When `op_valid` is low at an edge, `res_valid`, `wr_en`, `pc_load`, `link_wr` and `illegal` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A request is present this cycle |
| op_sel | input | 4 | Operation select code |
| operand | input | 16 | Value read from the effective address |
| eff_addr | input | 16 | Effective address of the operand |
| pc_in | input | 16 | Current program counter (return address) |
| skip_read | output | 1 | Combinational: the select does not use the operand |
| res_valid | output | 1 | A request was taken at the last edge |
| wr_en | output | 1 | Write `result` back to the effective address |
| result | output | 16 | Value computed for write-back |
| pc_load | output | 1 | Load the program counter from `pc_next` |
| pc_next | output | 16 | Branch target |
| link_wr | output | 1 | Write `link_data` into the register given by `link_idx` |
| link_idx | output | 4 | Workspace register index for the link write |
| link_data | output | 16 | Return address to save |
| illegal | output | 1 | The select code is unassigned |

## Verification
`skip_read` is combinational, so the bench reads it a short delay after driving the select, before any clock edge. All other results come from a single register stage and are due one edge after `op_valid` is sampled high. Each task drives its inputs on a falling edge and samples the outputs on the next falling edge, half a period after the capturing rising edge. The idle check then drops `op_valid` and samples again one edge later to confirm that the strobes fall.

// File: rtl/sop_pkg.sv
// Shared definitions for the single operand function unit.
// Assumes a 4-bit select; codes 12..15 are unassigned.
package sop_pkg;
    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_CLR  = 4'd0,
        SEL_SETO = 4'd1,
        SEL_INV  = 4'd2,
        SEL_NEG  = 4'd3,
        SEL_ABS  = 4'd4,
        SEL_SWPB = 4'd5,
        SEL_INC  = 4'd6,
        SEL_INCT = 4'd7,
        SEL_DEC  = 4'd8,
        SEL_DECT = 4'd9,
        SEL_BR   = 4'd10,
        SEL_BRL  = 4'd11
    } sop_sel_e;

    // Decoded class of a select code
    typedef struct packed {
        logic is_data;
        logic is_branch;
        logic is_link;
        logic no_read;
        logic bad;
    } sop_class_t;
endpackage

// File: rtl/sop_decode.sv
// Classifies a select code into data, branch, link, no-read and illegal.
// Assumes the encoding of sop_pkg; purely combinational.
module sop_decode
    import sop_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output sop_class_t       cls
);
    // Map each select code to its class bits
    always_comb begin
        cls = '0;
        case (sel)
            SEL_CLR, SEL_SETO: begin
                cls.is_data = 1'b1;
                cls.no_read = 1'b1;
            end
            SEL_INV, SEL_NEG, SEL_ABS, SEL_SWPB,
            SEL_INC, SEL_INCT, SEL_DEC, SEL_DECT: begin
                cls.is_data = 1'b1;
            end
            SEL_BR: begin
                cls.is_branch = 1'b1;
                cls.no_read   = 1'b1;
            end
            SEL_BRL: begin
                cls.is_branch = 1'b1;
                cls.is_link   = 1'b1;
                cls.no_read   = 1'b1;
            end
            default: cls.bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/sop_alu.sv
// Data path for single-operand value operations.
// Assumes DATA_W is even (byte swap exchanges halves). Codes outside the
// data set pass the operand through unchanged.
module sop_alu
    import sop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] res
);
    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] neg_v;
    logic [DATA_W-1:0] swp_v;

    // Two's-complement negation shared by negate and absolute value
    always_comb neg_v = '0 - opnd;

    // Exchange the upper and lower halves bit by bit
    for (genvar i = 0; i < HALF; i++) begin : g_swap
        assign swp_v[i]        = opnd[i+HALF];
        assign swp_v[i+HALF]   = opnd[i];
    end

    // Select the value for the requested operation
    always_comb begin
        case (sel)
            SEL_CLR:  res = '0;
            SEL_SETO: res = '1;
            SEL_INV:  res = ~opnd;
            SEL_NEG:  res = neg_v;
            SEL_ABS:  res = opnd[DATA_W-1] ? neg_v : opnd;
            SEL_SWPB: res = swp_v;
            SEL_INC:  res = opnd + DATA_W'(1);
            SEL_INCT: res = opnd + DATA_W'(2);
            SEL_DEC:  res = opnd - DATA_W'(1);
            SEL_DECT: res = opnd - DATA_W'(2);
            default:  res = opnd;
        endcase
    end
endmodule

// File: rtl/sop_branch.sv
// Forms the branch target and the link write for branch selects.
// Assumes the decoder has already classified the select.
module sop_branch #(
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 4,
    parameter int LINK_REG = 11
) (
    input  logic              is_branch,
    input  logic              is_link,
    input  logic [ADDR_W-1:0] ea,
    input  logic [ADDR_W-1:0] pc,
    output logic              load,
    output logic [ADDR_W-1:0] target,
    output logic              lnk,
    output logic [IDX_W-1:0]  lnk_idx,
    output logic [ADDR_W-1:0] lnk_val
);
    // Target and link values for a branch request
    always_comb begin
        load    = is_branch;
        target  = ea;
        lnk     = is_branch & is_link;
        lnk_idx = lnk ? IDX_W'(LINK_REG) : '0;
        lnk_val = lnk ? pc : '0;
    end
endmodule

// File: rtl/sop_unit.sv
// Single operand function unit: one register stage after the decoder,
// value path and branch path. Assumes the operand is already fetched for
// selects that need it (skip_read tells the sequencer which do not).
module sop_unit
    import sop_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 16,
    parameter int IDX_W    = 4,
    parameter int LINK_REG = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              skip_read,
    output logic              res_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_next,
    output logic              link_wr,
    output logic [IDX_W-1:0]  link_idx,
    output logic [ADDR_W-1:0] link_data,
    output logic              illegal
);
    sop_class_t        cls;
    logic [DATA_W-1:0] alu_res;
    logic              br_load;
    logic [ADDR_W-1:0] br_target;
    logic              br_lnk;
    logic [IDX_W-1:0]  br_idx;
    logic [ADDR_W-1:0] br_val;

    sop_decode u_dec (
        .sel (op_sel),
        .cls (cls)
    );

    sop_alu #(.DATA_W(DATA_W)) u_alu (
        .sel  (op_sel),
        .opnd (operand),
        .res  (alu_res)
    );

    sop_branch #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINK_REG(LINK_REG)) u_br (
        .is_branch (cls.is_branch),
        .is_link   (cls.is_link),
        .ea        (eff_addr),
        .pc        (pc_in),
        .load      (br_load),
        .target    (br_target),
        .lnk       (br_lnk),
        .lnk_idx   (br_idx),
        .lnk_val   (br_val)
    );

    // Tell the sequencer whether the operand read can be skipped
    always_comb skip_read = cls.no_read;

    // Strobes: one cycle pulse per accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            wr_en     <= 1'b0;
            pc_load   <= 1'b0;
            link_wr   <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            res_valid <= op_valid;
            wr_en     <= op_valid & cls.is_data;
            pc_load   <= op_valid & br_load;
            link_wr   <= op_valid & br_lnk;
            illegal   <= op_valid & cls.bad;
        end
    end

    // Data registers: capture on each accepted request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            pc_next   <= '0;
            link_idx  <= '0;
            link_data <= '0;
        end else if (op_valid) begin
            result    <= alu_res;
            pc_next   <= br_target;
            link_idx  <= br_idx;
            link_data <= br_val;
        end
    end

    // R2/R8/R11: at most one of write-back, branch and illegal per result
    a_r11_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, pc_load, illegal}));

    // R9: a link write only ever comes with a branch
    a_r9_link_with_branch: assert property (@(posedge clk) disable iff (!rst_n)
        link_wr |-> (pc_load && link_idx == IDX_W'(LINK_REG)));

    // R12: results only follow a sampled request
    a_r12_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R12: no strobes without a request
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !(res_valid || wr_en || pc_load || link_wr || illegal));

    // R11: illegal codes pass the operand through
    a_r11_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && cls.bad |=> (illegal && result == $past(operand)));

    // R8: branch target is the effective address of the request
    a_r8_target: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && br_load |=> (pc_load && pc_next == $past(eff_addr)));

    // R9: saved return address is the program counter of the request
    a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && br_lnk |=> link_data == $past(pc_in));

    // R10: a select that skips the read is never illegal
    a_r10_skip_legal: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && skip_read |=> !illegal);
endmodule

// File: tb/tb_sop_unit.sv
module tb_sop_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic [15:0] operand;
    logic [15:0] eff_addr;
    logic [15:0] pc_in;
    logic        skip_read;
    logic        res_valid;
    logic        wr_en;
    logic [15:0] result;
    logic        pc_load;
    logic [15:0] pc_next;
    logic        link_wr;
    logic [3:0]  link_idx;
    logic [15:0] link_data;
    logic        illegal;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    sop_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .operand(operand), .eff_addr(eff_addr), .pc_in(pc_in),
        .skip_read(skip_read), .res_valid(res_valid), .wr_en(wr_en),
        .result(result), .pc_load(pc_load), .pc_next(pc_next),
        .link_wr(link_wr), .link_idx(link_idx), .link_data(link_data),
        .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request on a falling edge, sample one edge later
    task automatic issue(input logic [3:0] s, input logic [15:0] v,
                         input logic [15:0] ea, input logic [15:0] pc);
        @(negedge clk);
        op_valid = 1'b1; op_sel = s; operand = v; eff_addr = ea; pc_in = pc;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic data_op(input string tag, input logic [3:0] s,
                           input logic [15:0] v, input logic [15:0] exp);
        issue(s, v, 16'h1234, 16'h4321);
        chk({tag, " result"}, result, exp);
        chk({tag, " wr_en"}, {15'd0, wr_en}, 16'd1);
        chk({tag, " pc_load"}, {15'd0, pc_load}, 16'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; op_valid = 1'b1; op_sel = 4'd1; operand = 16'hAAAA;
        eff_addr = 16'h5555; pc_in = 16'h7777;
        repeat (3) @(negedge clk);
        chk("R1 result", result, 16'h0);
        chk("R1 strobes", {11'd0, res_valid, wr_en, pc_load, link_wr, illegal}, 16'h0);
        chk("R1 pc_next", pc_next, 16'h0);
        chk("R1 link", {link_idx, 12'd0} | link_data, 16'h0);
        op_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_fill();
        data_op("R2 clr", 4'd0, 16'hBEEF, 16'h0000);
        data_op("R2 seto", 4'd1, 16'h0123, 16'hFFFF);
    endtask

    task automatic t_inv();
        data_op("R3 inv", 4'd2, 16'h0F5A, 16'hF0A5);
    endtask

    task automatic t_neg();
        data_op("R4 neg", 4'd3, 16'h0001, 16'hFFFF);
        data_op("R4 neg min", 4'd3, 16'h8000, 16'h8000);
        data_op("R4 neg zero", 4'd3, 16'h0000, 16'h0000);
    endtask

    task automatic t_abs();
        data_op("R5 abs pos", 4'd4, 16'h1234, 16'h1234);
        data_op("R5 abs neg", 4'd4, 16'hFFFE, 16'h0002);
        data_op("R5 abs min", 4'd4, 16'h8000, 16'h8000);
    endtask

    task automatic t_swap();
        data_op("R6 swpb", 4'd5, 16'h12AB, 16'hAB12);
    endtask

    task automatic t_step();
        data_op("R7 inc", 4'd6, 16'hFFFF, 16'h0000);
        data_op("R7 inct", 4'd7, 16'hFFFF, 16'h0001);
        data_op("R7 dec", 4'd8, 16'h0000, 16'hFFFF);
        data_op("R7 dect", 4'd9, 16'h0001, 16'hFFFF);
        data_op("R7 inc mid", 4'd6, 16'h7FFF, 16'h8000);
    endtask

    task automatic t_branch();
        issue(4'd10, 16'h1111, 16'hA0B0, 16'h0100);
        chk("R8 pc_load", {15'd0, pc_load}, 16'd1);
        chk("R8 pc_next", pc_next, 16'hA0B0);
        chk("R8 no wr/link", {14'd0, wr_en, link_wr}, 16'd0);
    endtask

    task automatic t_link();
        issue(4'd11, 16'h2222, 16'h0C40, 16'h0302);
        chk("R9 pc_load", {15'd0, pc_load}, 16'd1);
        chk("R9 pc_next", pc_next, 16'h0C40);
        chk("R9 link_wr", {15'd0, link_wr}, 16'd1);
        chk("R9 link_data", link_data, 16'h0302);
        chk("R9 link_idx", {12'd0, link_idx}, 16'd11);
        chk("R9 no wr", {15'd0, wr_en}, 16'd0);
    endtask

    task automatic t_skip();
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            op_sel = 4'(c);
            #1;
            chk($sformatf("R10 skip sel=%0d", c), {15'd0, skip_read},
                (c == 0 || c == 1 || c == 10 || c == 11) ? 16'd1 : 16'd0);
        end
    endtask

    task automatic t_illegal();
        for (int c = 12; c < 16; c++) begin
            issue(4'(c), 16'h5A00 + 16'(c), 16'h0040, 16'h0080);
            chk($sformatf("R11 illegal sel=%0d", c), {15'd0, illegal}, 16'd1);
            chk("R11 result", result, 16'h5A00 + 16'(c));
            chk("R11 quiet", {13'd0, wr_en, pc_load, link_wr}, 16'd0);
        end
    endtask

    task automatic t_idle();
        issue(4'd6, 16'h0010, 16'h0, 16'h0);
        chk("R12 valid", {15'd0, res_valid}, 16'd1);
        chk("R12 timing", result, 16'h0011);
        @(negedge clk);
        chk("R12 idle strobes", {11'd0, res_valid, wr_en, pc_load, link_wr, illegal}, 16'd0);
        chk("R12 idle hold", result, 16'h0011);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_inv();
        t_neg();
        t_abs();
        t_swap();
        t_step();
        t_branch();
        t_link();
        t_skip();
        t_illegal();
        t_idle();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule